// File: doc/BRIEF.md
# Prescaled Modulo Timer with Sticky Overflow Flag

This block is a 16-bit up-counter that advances on a divided clock tick and wraps back to zero once it passes a programmable modulo value. Each wrap can raise a sticky overflow flag. When overflow interrupts are enabled, the flag drives a level-sensitive interrupt line that stays high until software lowers the flag. The counting source is either the system clock, a synchronous external tick input, or nothing.

Software lowers the flag with a two-step handshake. It first reads the control word while the flag is set, then writes the control word with the flag bit at zero. A wrap that lands between those two steps cancels the clear, so an overflow is never lost. A wrap threshold can hold the flag back until a chosen number of wraps has taken place. Configuration fields are locked until an unlock bit is set.

Register access uses a single-cycle strobe bus. The address selects one of four words: 0 is the control word, 1 the counter, 2 the modulo and 3 the configuration. Read data is registered and appears on `rdata` one clock after `rd_en`.

Top module: `ovf_mod_timer`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0, the modulo reads 0xFFFF, the configuration reads 0 and `irq` is low.
- R2: With clock source 1 (control bits [4:3]) and prescale code n (control bits [2:0]), a counter read issued k cycles after the source started returns (k >> n) mod (M+1) for modulo M; the counter wraps to 0 after reaching M.
- R3: Clock source 0 or 3 holds the counter; clock source 2 advances the counter once per `ext_tick` pulse (prescale 0).
- R4: A control write that changes the clock-source field restarts both the counter and the prescaler at zero; any write to the counter register loads zero.
- R5: Configuration bit 8 is the unlock bit and is always writable. While it is clear, writes to the modulo, the threshold (configuration bits [4:0]) and the control fields prescale, source and interrupt enable are ignored.
- R6: With threshold 0, every wrap sets the overflow flag (control bit 7), and the flag stays set until a valid clear.
- R7: `irq` equals the flag ANDed with the interrupt enable (control bit 6), and it stays high for as long as both are set.
- R8: A control read that returns the flag as 1, followed by a control write with bit 7 at 0, clears the flag.
- R9: A wrap that occurs after that read, including in the cycle of the write, cancels the clear, so the flag and `irq` stay high.
- R10: A control write with bit 7 at 0 that is not preceded by a read that saw the flag set leaves the flag unchanged; writing 1 to bit 7 never sets it.
- R11: With a nonzero threshold T, the flag is set only on the T-th wrap, and the count of wraps then starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | Synchronous external count pulse, used with source 2 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 control, 1 counter, 2 modulo, 3 configuration |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid one cycle after `rd_en` |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench runs random prescale codes, modulo values and wait lengths against a closed-form count model. A prescaler off by one edge, or a wrap that fires at M instead of after M, shows up there as a wrong count value. The bench also lets a wrap land between the read and the write of the clear handshake: a design that ignores that race drops `irq` and loses the overflow. It issues a blind zero write and a write of one, which a design with a plain write-to-clear or a writable flag would act on. Finally it checks that the flag rises on exactly the third wrap when the threshold is 3, so a design that counts from the wrong base shows an early or late interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CNT  = 2'd1,
    A_MOD  = 2'd2,
    A_CFG  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_HOLD = 2'd3
  } clk_src_e;

  localparam int SRC_LO   = 3;
  localparam int IE_BIT   = 6;
  localparam int FLAG_BIT = 7;
  localparam int UNLK_BIT = 8;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           tick,
  input  logic [PSW-1:0] ps,
  output logic           adv
);
  localparam int PCW = (1 << PSW) - 1;

  logic [PCW-1:0] pcnt;
  logic [PCW-1:0] lim;

  assign lim = PCW'((1 << ps) - 1);
  assign adv = tick && !clr && (pcnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= (pcnt == lim) ? '0 : pcnt + PCW'(1);
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] modv,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic at_top;

  assign at_top = (cnt >= modv);
  assign wrap   = adv && !clr && at_top;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= at_top ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap,
  input  logic [TW-1:0] thr,
  input  logic          rd_ctrl,
  input  logic          wr_ctrl,
  input  logic          wbit,
  input  logic          ie_d,
  output logic          flag_q,
  output logic          armed_q,
  output logic          irq
);
  logic [TW-1:0] wcnt;
  logic          hit;
  logic          clr_ok;
  logic          flag_d;

  assign hit    = wrap && ((thr == '0) || ({1'b0, wcnt} + (TW+1)'(1) >= {1'b0, thr}));
  assign clr_ok = wr_ctrl && !wbit && armed_q && !wrap;

  always_comb begin
    flag_d = flag_q;
    if (hit)         flag_d = 1'b1;
    else if (clr_ok) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt    <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wrap) wcnt <= hit ? '0 : wcnt + TW'(1);
      flag_q <= flag_d;
      irq    <= flag_d && ie_d;
      if (wrap || wr_ctrl)        armed_q <= 1'b0;
      else if (rd_ctrl && flag_q) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ovf_mod_timer.sv
module ovf_mod_timer #(
  parameter int CW  = 16,
  parameter int PSW = 3,
  parameter int TW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq
);
  import tmr_pkg::*;

  logic [PSW-1:0] ps_q;
  logic [1:0]     src_q;
  logic           ie_q;
  logic [CW-1:0]  mod_q;
  logic [TW-1:0]  thr_q;
  logic           unlock_q;

  logic wr_ctrl, wr_cnt, wr_mod, wr_cfg, rd_ctrl;
  logic ctl_ok, restart, tick_src, adv, wrap, ie_d;
  logic flag_q, armed_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ctrl_word, cfg_word;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cnt  = wr_en && (addr == A_CNT);
  assign wr_mod  = wr_en && (addr == A_MOD);
  assign wr_cfg  = wr_en && (addr == A_CFG);
  assign rd_ctrl = rd_en && (addr == A_CTRL);

  assign ctl_ok   = wr_ctrl && unlock_q;
  assign restart  = ctl_ok && (wdata[SRC_LO+1:SRC_LO] != src_q);
  assign tick_src = (src_q == SRC_SYS) || ((src_q == SRC_EXT) && ext_tick);
  assign ie_d     = ctl_ok ? wdata[IE_BIT] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q     <= '0;
      src_q    <= SRC_OFF;
      ie_q     <= 1'b0;
      mod_q    <= '1;
      thr_q    <= '0;
      unlock_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        unlock_q <= wdata[UNLK_BIT];
        if (unlock_q) thr_q <= wdata[TW-1:0];
      end
      if (ctl_ok) begin
        ps_q  <= wdata[PSW-1:0];
        src_q <= wdata[SRC_LO+1:SRC_LO];
        ie_q  <= wdata[IE_BIT];
      end
      if (wr_mod && unlock_q) mod_q <= wdata;
    end
  end

  tmr_prescaler #(.PSW(PSW)) u_pre (
    .clk(clk), .rst(rst), .clr(restart), .tick(tick_src), .ps(ps_q), .adv(adv)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(restart || wr_cnt), .adv(adv),
    .modv(mod_q), .cnt(cnt), .wrap(wrap)
  );

  tmr_flag #(.TW(TW)) u_flag (
    .clk(clk), .rst(rst), .wrap(wrap), .thr(thr_q), .rd_ctrl(rd_ctrl),
    .wr_ctrl(wr_ctrl), .wbit(wdata[FLAG_BIT]), .ie_d(ie_d),
    .flag_q(flag_q), .armed_q(armed_q), .irq(irq)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[PSW-1:0]         = ps_q;
    ctrl_word[SRC_LO+1:SRC_LO] = src_q;
    ctrl_word[IE_BIT]          = ie_q;
    ctrl_word[FLAG_BIT]        = flag_q;
    cfg_word = '0;
    cfg_word[TW-1:0]           = thr_q;
    cfg_word[UNLK_BIT]         = unlock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (reg_addr_e'(addr))
        A_CTRL:  rdata <= ctrl_word;
        A_CNT:   rdata <= cnt;
        A_MOD:   rdata <= mod_q;
        default: rdata <= cfg_word;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic          ctl_wbit,
  input logic          irq,
  input logic          flag_q,
  input logic          ie_q,
  input logic          armed_q,
  input logic          wrap,
  input logic          unlock_q,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] mod_q
);
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (flag_q && ie_q)); // R7
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_en && addr == 2'd0 && !ctl_wbit)) |=> flag_q); // R6
  AST_BLIND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (flag_q && wr_en && addr == 2'd0 && !armed_q) |=> flag_q); // R10
  AST_RACE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_q && wrap) |=> flag_q); // R9
  AST_LOCKED_MOD: assert property (@(posedge clk) disable iff (rst)
    (!unlock_q && wr_en && addr == 2'd2) |=> $stable(mod_q)); // R5
endmodule

bind ovf_mod_timer tmr_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .ctl_wbit(wdata[7]),
  .irq(irq), .flag_q(flag_q), .ie_q(ie_q), .armed_q(armed_q), .wrap(wrap),
  .unlock_q(unlock_q), .cnt(cnt), .mod_q(mod_q)
);

// File: tb/ovf_mod_timer_test.sv
module ovf_mod_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int ecount = 0;
  int e0 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) ecount <= ecount + 1;

  ovf_mod_timer uut (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_until(input int k);
    while (ecount - e0 < k) @(negedge clk);
  endtask

  function automatic int model_cnt(input int k, input int n, input int m);
    return (k >> n) % (m + 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 cnt", d, 0);
    rd(2'd2, d); chk("R1 mod", d, 16'hFFFF);
    rd(2'd3, d); chk("R1 cfg", d, 0);
    chk("R1 irq", irq, 0);

    // R5 locked writes ignored
    wr(2'd2, 16'h0010);
    rd(2'd2, d); chk("R5 mod locked", d, 16'hFFFF);
    wr(2'd0, 16'h0008);
    repeat (5) @(negedge clk);
    rd(2'd1, d); chk("R5 ctrl locked cnt", d, 0);
    wr(2'd3, 16'h0100);

    // R2 random prescale / modulo / wait
    for (int i = 0; i < 14; i++) begin
      int n, m, w;
      n = $urandom % 4;
      m = (i == 0) ? 16'hFFFF : $urandom_range(300, 0);
      w = $urandom % 1500;
      wr(2'd2, m[15:0]);
      wr(2'd0, 16'(n));
      wr(2'd0, 16'(8 | n));
      e0 = ecount;
      repeat (w) @(negedge clk);
      rd(2'd1, d);
      chk("R2 count", d, model_cnt(ecount - 1 - e0, n, m));
    end

    // R4 counter write loads zero
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0008);
    repeat (30) @(negedge clk);
    wr(2'd1, 16'h1234);
    e0 = ecount;
    repeat (10) @(negedge clk);
    rd(2'd1, d); chk("R4 cnt write zero", d, 10);

    // R3 / R4 source change restart, source 0, 2, 3
    wr(2'd0, 16'h0000);
    repeat (20) @(negedge clk);
    rd(2'd1, d); chk("R3 src0 hold", d, 0);
    wr(2'd0, 16'h0010);
    for (int p = 0; p < 7; p++) begin
      ext_tick = 1'b1; @(negedge clk);
      ext_tick = 1'b0; @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(2'd1, d); chk("R3 ext ticks", d, 7);
    wr(2'd0, 16'h0018);
    repeat (10) @(negedge clk);
    rd(2'd1, d); chk("R4 restart src3 hold", d, 0);

    // clean flag state
    rd(2'd0, d);
    wr(2'd0, 16'h0000);
    rd(2'd0, d); chk("R8 initial clear", d, 16'h0000);

    // R6 / R7 flag on wrap, irq level
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0048);
    e0 = ecount;
    for (int k = 1; k <= 10; k++) begin
      wait_until(k);
      chk("R7 irq level", irq, (k >= 4) ? 1 : 0);
    end
    wr(2'd0, 16'h0040);
    chk("R10 blind write keeps irq", irq, 1);
    rd(2'd0, d); chk("R6 flag sticky", d, 16'h00C0);
    wr(2'd0, 16'h0040);
    chk("R8 clear irq", irq, 0);
    rd(2'd0, d); chk("R8 flag cleared", d, 16'h0040);

    // R10 write without read, write of one
    wr(2'd0, 16'h0048);
    e0 = ecount;
    wait_until(6);
    wr(2'd0, 16'h0040);
    chk("R10 no read no clear", irq, 1);
    rd(2'd0, d);
    wr(2'd0, 16'h0040);
    chk("R8 handshake clear", irq, 0);
    wr(2'd0, 16'h00C0);
    rd(2'd0, d); chk("R10 write one ignored", d, 16'h0040);

    // R9 wrap between read and write cancels clear
    wr(2'd2, 16'd15);
    wr(2'd0, 16'h004A);
    e0 = ecount;
    wait_until(70);
    rd(2'd0, d); chk("R6 flag after wrap", d, 16'h00CA);
    wait_until(130);
    wr(2'd0, 16'h004A);
    chk("R9 race keeps irq", irq, 1);
    rd(2'd0, d); chk("R9 race keeps flag", d, 16'h00CA);
    wr(2'd0, 16'h004A);
    chk("R8 clear after race", irq, 0);

    // R11 wrap threshold
    wr(2'd0, 16'h0040);
    wr(2'd3, 16'h0103);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0048);
    e0 = ecount;
    wait_until(11);
    chk("R11 before third wrap", irq, 0);
    wait_until(13);
    chk("R11 at third wrap", irq, 1);
    wr(2'd0, 16'h0040);
    rd(2'd3, d); chk("R5 cfg readback", d, 16'h0103);

    // R5 relock
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'h0055);
    rd(2'd2, d); chk("R5 relocked mod", d, 3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule